// File: doc/BRIEF.md
# Packed Lane Shuffle Unit (Interleave and Saturating Narrow)

This unit reorganises the lanes of two 64-bit packed operands. It has two families of operation. Interleave operations take elements from either the lower or the upper half of both sources and alternate them in the result, at byte, word (16-bit) or doubleword (32-bit) granularity. Interleaving with zero or with a sign-mask operand is how bytes are widened to words. Narrowing operations convert every lane of both sources to a lane of half the width and clamp each value to the range of the narrower type instead of dropping its upper bits.

The result is registered, so a new operation can be issued on every clock and its answer appears one cycle later. A 4x4 matrix of 16-bit elements can be transposed with the unit alone. Four word-granularity interleaves on row pairs come first. Four doubleword-granularity interleaves on those intermediate results then produce the four columns.

Top module: `shf_unit`

## Requirements
- R1: An active-high synchronous reset drives the result to all zeros, whatever the inputs are.
- R2: The result after a rising clock edge is the function of the inputs sampled at that edge. Each new operation therefore takes one cycle.
- R3: The opcode is 2 bits: 0 selects interleave-low, 1 interleave-high, 2 signed-saturating narrow and 3 unsigned-saturating narrow. The size select is 2 bits: 0 byte, 1 word, 2 doubleword, 3 quadword.
- R4: For interleave-low at element width W, elements are numbered from the least significant end. Result element 2k is element k of source A and result element 2k+1 is element k of source B, for every k in the lower half of the element positions.
- R5: Interleave-high follows the same placement as R4, but takes elements from the upper half of each source: element N/2+k, where N is the number of elements.
- R6: In a signed narrow, the size select names the source lane width W (word or doubleword). Each source lane is read as a signed value and clamped to the signed range of W/2 bits. The A lanes fill the low half of the result in order and the B lanes fill the high half.
- R7: An unsigned narrow reads each source lane as signed and clamps it to 0 through 2^(W/2)-1. Lane placement is the same as in R6.
- R8: Combinations with no defined meaning give an all-zero result. These are interleave with size 3, and narrow with size 0 or 3.
- R9: Rows r0 to r3 of a 4x4 16-bit matrix can be transposed. Word interleave-low and interleave-high are applied to (r0,r1) and to (r2,r3). Doubleword interleaves are then applied to the pairs of intermediate results. This yields each column with row 0 in the least significant word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_a_i | input | 64 | First packed source operand |
| src_b_i | input | 64 | Second packed source operand |
| op_i | input | 2 | Operation select (R3) |
| sz_i | input | 2 | Lane size select (R3) |
| res_o | output | 64 | Registered packed result |

## Verification
Every result falls due exactly one clock after its operands and controls are sampled, including the zero forced by reset. The bench changes inputs on the falling edge. It compares the output against its behavioural model on the next falling edge, which puts exactly one register stage between stimulus and check. The transpose sequence feeds the captured intermediate results back as operands, one cycle apart. The column checks therefore also confirm that nothing from an earlier operation persists beyond that single stage.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        OP_ILV_LO = 2'd0,
        OP_ILV_HI = 2'd1,
        OP_NRW_S  = 2'd2,
        OP_NRW_U  = 2'd3
    } shf_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } shf_sz_e;

    typedef struct packed {
        shf_op_e op;
        shf_sz_e sz;
    } shf_ctl_t;

    // Number of granularities the interleave path supports (byte, word, dword)
    localparam int ILV_GRANS = 3;

    function automatic logic is_narrow(input shf_op_e op);
        return op == OP_NRW_S || op == OP_NRW_U;
    endfunction

    function automatic logic ctl_defined(input shf_ctl_t c);
        if (is_narrow(c.op))
            return c.sz == SZ_WORD || c.sz == SZ_DWORD;
        return c.sz != SZ_QWORD;
    endfunction

endpackage

// File: rtl/shf_sat_lane.sv
module shf_sat_lane #(
    parameter int SRC_W = 16
) (
    input  logic [SRC_W-1:0]   src_i,
    input  logic               uns_i,
    output logic [SRC_W/2-1:0] dst_o
);
    localparam int DST_W = SRC_W / 2;
    localparam logic signed [SRC_W-1:0] SMAX = SRC_W'((1 << (DST_W - 1)) - 1);
    localparam logic signed [SRC_W-1:0] SMIN = -SMAX - 1;
    localparam logic signed [SRC_W-1:0] UMAX = SRC_W'((1 << DST_W) - 1);

    logic signed [SRC_W-1:0] val;
    assign val = signed'(src_i);

    always_comb begin
        dst_o = src_i[DST_W-1:0];
        if (uns_i) begin
            if (val < 0)
                dst_o = '0;
            else if (val > UMAX)
                dst_o = '1;
        end else begin
            if (val > SMAX)
                dst_o = {1'b0, {(DST_W-1){1'b1}}};
            else if (val < SMIN)
                dst_o = {1'b1, {(DST_W-1){1'b0}}};
        end
    end
endmodule

// File: rtl/shf_interleave.sv
module shf_interleave
    import shf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              hi_i,
    input  shf_sz_e           sz_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] lo_c [ILV_GRANS];
    logic [DATA_W-1:0] hi_c [ILV_GRANS];

    for (genvar g = 0; g < ILV_GRANS; g++) begin : g_gran
        localparam int EW   = 8 << g;
        localparam int NEL  = DATA_W / EW;
        localparam int HALF = NEL / 2;
        for (genvar k = 0; k < HALF; k++) begin : g_pair
            assign lo_c[g][(2*k)*EW   +: EW] = a_i[k*EW +: EW];
            assign lo_c[g][(2*k+1)*EW +: EW] = b_i[k*EW +: EW];
            assign hi_c[g][(2*k)*EW   +: EW] = a_i[(HALF+k)*EW +: EW];
            assign hi_c[g][(2*k+1)*EW +: EW] = b_i[(HALF+k)*EW +: EW];
        end
    end

    always_comb begin
        case (sz_i)
            SZ_BYTE:  res_o = hi_i ? hi_c[0] : lo_c[0];
            SZ_WORD:  res_o = hi_i ? hi_c[1] : lo_c[1];
            SZ_DWORD: res_o = hi_i ? hi_c[2] : lo_c[2];
            default:  res_o = '0;
        endcase
    end
endmodule

// File: rtl/shf_narrow.sv
module shf_narrow
    import shf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              uns_i,
    input  shf_sz_e           sz_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] cand [1:2];

    for (genvar g = 1; g <= 2; g++) begin : g_src
        localparam int SW  = 8 << g;
        localparam int DW  = SW / 2;
        localparam int NEL = DATA_W / SW;
        for (genvar k = 0; k < NEL; k++) begin : g_lane
            shf_sat_lane #(.SRC_W(SW)) u_sat_a (
                .src_i (a_i[k*SW +: SW]),
                .uns_i (uns_i),
                .dst_o (cand[g][k*DW +: DW])
            );
            shf_sat_lane #(.SRC_W(SW)) u_sat_b (
                .src_i (b_i[k*SW +: SW]),
                .uns_i (uns_i),
                .dst_o (cand[g][(NEL+k)*DW +: DW])
            );
        end
    end

    always_comb begin
        case (sz_i)
            SZ_WORD:  res_o = cand[1];
            SZ_DWORD: res_o = cand[2];
            default:  res_o = '0;
        endcase
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        sz_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int HALF_W = DATA_W / 2;

    shf_ctl_t          ctl;
    logic [DATA_W-1:0] ilv_res;
    logic [DATA_W-1:0] nrw_res;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] res_q;

    assign ctl.op = shf_op_e'(op_i);
    assign ctl.sz = shf_sz_e'(sz_i);

    shf_interleave #(.DATA_W(DATA_W)) u_ilv (
        .a_i   (src_a_i),
        .b_i   (src_b_i),
        .hi_i  (ctl.op == OP_ILV_HI),
        .sz_i  (ctl.sz),
        .res_o (ilv_res)
    );

    shf_narrow #(.DATA_W(DATA_W)) u_nrw (
        .a_i   (src_a_i),
        .b_i   (src_b_i),
        .uns_i (ctl.op == OP_NRW_U),
        .sz_i  (ctl.sz),
        .res_o (nrw_res)
    );

    always_comb begin
        if (!ctl_defined(ctl))
            nxt = '0;
        else if (is_narrow(ctl.op))
            nxt = nrw_res;
        else
            nxt = ilv_res;
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else
            res_q <= nxt;
    end

    assign res_o = res_q;

    // The lowest byte of A always lands at the bottom for a low interleave
    assert_ilv_lo_base_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd0 && sz_i != 2'd3) |=> res_o[7:0] == $past(src_a_i[7:0]));

    // Byte interleave-high pairs the first upper-half bytes of A and B
    assert_ilv_hi_byte_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd1 && sz_i == 2'd0) |=>
        res_o[15:0] == {$past(src_b_i[HALF_W +: 8]), $past(src_a_i[HALF_W +: 8])});

    // A large positive word clamps to the signed byte maximum
    assert_nrw_s_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd2 && sz_i == 2'd1 && $signed(src_a_i[15:0]) > 127) |=>
        res_o[7:0] == 8'h7f);

    // A negative word clamps to zero under unsigned narrowing
    assert_nrw_u_neg_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd3 && sz_i == 2'd1 && src_a_i[15]) |=> res_o[7:0] == 8'h00);

    assert_undef_zero_R8: assert property (@(posedge clk) disable iff (rst)
        ((!op_i[1] && sz_i == 2'd3) || (op_i[1] && (sz_i == 2'd0 || sz_i == 2'd3)))
        |=> res_o == '0);
endmodule

// File: tb/shf_unit_tb_top.sv
module shf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [1:0]  op;
    logic [1:0]  sz;
    logic [63:0] res;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    shf_unit #(.DATA_W(64)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .src_a_i (src_a),
        .src_b_i (src_b),
        .op_i    (op),
        .sz_i    (sz),
        .res_o   (res)
    );

    function automatic logic [63:0] ref_model(input logic [63:0] a, input logic [63:0] b,
                                              input logic [1:0] o, input logic [1:0] s);
        logic [63:0] r = '0;
        logic [63:0] mask;
        int w, n, base, d;
        longint v, lo, hi;
        if (o < 2) begin
            if (s == 3) return '0;
            w = 8 << s;
            n = 64 / w;
            base = (o == 1) ? n / 2 : 0;
            mask = (64'd1 << w) - 1;
            for (int k = 0; k < n / 2; k++) begin
                r |= ((a >> ((base + k) * w)) & mask) << (2 * k * w);
                r |= ((b >> ((base + k) * w)) & mask) << ((2 * k + 1) * w);
            end
            return r;
        end
        if (s != 1 && s != 2) return '0;
        w = 8 << s;
        d = w / 2;
        n = 64 / w;
        mask = (64'd1 << w) - 1;
        lo = (o == 3) ? 0 : -(longint'(1) << (d - 1));
        hi = (o == 3) ? (longint'(1) << d) - 1 : (longint'(1) << (d - 1)) - 1;
        for (int k = 0; k < 2 * n; k++) begin
            logic [63:0] raw;
            raw = (k < n) ? ((a >> (k * w)) & mask) : ((b >> ((k - n) * w)) & mask);
            v = longint'(raw);
            if (raw[w-1]) v = v - (longint'(1) << w);
            if (v < lo) v = lo;
            if (v > hi) v = hi;
            r |= (64'(v) & ((64'd1 << d) - 1)) << (k * d);
        end
        return r;
    endfunction

    function automatic string req_of(input logic [1:0] o, input logic [1:0] s);
        if ((o < 2 && s == 3) || (o >= 2 && (s == 0 || s == 3))) return "R8";
        case (o)
            2'd0:    return "R4";
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at a falling edge; the result is due after one rising edge (R2, R3 encoding)
    task automatic run1(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] o, input logic [1:0] s, output logic [63:0] got);
        logic [63:0] exp;
        src_a = a; src_b = b; op = o; sz = s;
        exp = ref_model(a, b, o, s);
        @(negedge clk);
        got = res;
        check({req_of(o, s), " R2 R3"}, got, exp);
    endtask

    initial begin
        logic [63:0] g;
        logic [63:0] row [4];
        logic [63:0] t   [4];
        logic [63:0] col;
        rst = 1'b1;
        src_a = 64'hdead_beef_0123_4567;
        src_b = 64'hffff_0000_8080_7f7f;
        op = 2'd0; sz = 2'd1;
        repeat (2) @(negedge clk);
        check("R1 reset", res, 64'd0);
        rst = 1'b0;

        // Interleave, every size
        for (int o = 0; o < 2; o++)
            for (int s = 0; s < 4; s++)
                run1(64'h8877_6655_4433_2211, 64'hfffe_fdfc_fbfa_f9f8, 2'(o), 2'(s), g);

        // Narrowing boundaries, word and dword sources, both signs
        for (int o = 2; o < 4; o++) begin
            run1(64'h007f_0080_ff80_ff7f, 64'h7fff_8000_00ff_0100, 2'(o), 2'd1, g);
            run1(64'h0000_7fff_ffff_8000, 64'h0000_8000_0001_0000, 2'(o), 2'd2, g);
            run1(64'h1234_5678_9abc_def0, 64'h0, 2'(o), 2'd0, g);  // R8
            run1(64'h1234_5678_9abc_def0, 64'h0, 2'(o), 2'd3, g);  // R8
        end

        // Mid-run reset ignores live inputs (R1)
        src_a = 64'hffff_ffff_ffff_ffff; src_b = src_a; op = 2'd1; sz = 2'd0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", res, 64'd0);
        rst = 1'b0;

        // 4x4 word transpose (R9)
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                row[r][c*16 +: 16] = 16'(16'h0a00 + r * 16 + c);
        run1(row[0], row[1], 2'd0, 2'd1, t[0]);
        run1(row[0], row[1], 2'd1, 2'd1, t[1]);
        run1(row[2], row[3], 2'd0, 2'd1, t[2]);
        run1(row[2], row[3], 2'd1, 2'd1, t[3]);
        for (int c = 0; c < 4; c++) begin
            logic [63:0] exp_col;
            for (int r = 0; r < 4; r++) exp_col[r*16 +: 16] = row[r][c*16 +: 16];
            run1(t[(c / 2)], t[(c / 2) + 2], 2'((c % 2)), 2'd2, col);
            check("R9 transpose column", col, exp_col);
        end

        // Mixed back-to-back operations, compared every clock
        for (int i = 0; i < 400; i++)
            run1({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom), g);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule